// File: doc/BRIEF.md
# ADC Conversion Clock Prescaler

This block produces the clock enable that paces an analog-to-digital converter. Two free-running enables arrive from the same clock domain: one marks bus-clock ticks, the other marks external oscillator ticks. A control word selects which of the two is counted, and a 3-bit divide code selects a power-of-two ratio. The block issues a single-cycle `conv_ce` pulse once per N counted ticks. Because both sources are plain enables, there is no gated or multiplexed clock to fall foul of glitches.

Software writes a 4-bit control word through a simple write port and can read back what it wrote. A converter that is mid-conversion holds `conv_busy` high. While it does so, the setting in use is frozen. A write made during that time is kept as pending and takes effect once the busy signal drops. Each time a setting takes effect, the divide counter restarts, so the first pulse under the new setting comes a whole new period later.

Top module: `adc_clk_prescaler`

## Requirements
- R1: Divide codes 000, 001, 010 and 011 (control bits [2:0]) give a pulse on every 1st, 2nd, 4th and 8th selected-source tick respectively; `conv_ce` is high in the cycle after the clock edge that samples that tick.
- R2: A divide code with bit 2 set gives one pulse every 16 selected-source ticks, whatever bits [1:0] hold.
- R3: Control bit 3 picks the source: 1 counts `bus_ce` and 0 counts `osc_ce`; ticks on the unselected input never produce a pulse.
- R4: A synchronous reset clears the control word to 0000, so the oscillator enable is counted at divide-by-1, and drives `conv_ce` low.
- R5: When `conv_busy` is high at a clock edge, the source and ratio in use do not change at that edge; a write made then is held as pending.
- R6: A write made while `conv_busy` is low takes effect at that edge. A pending write takes effect at the first edge that sees `conv_busy` low, and a fresh write at that same edge wins.
- R7: When a setting takes effect, the divide counter returns to zero, any source tick sampled at that edge is discarded, and `conv_ce` is low in the following cycle.
- R8: `rd_data` returns the last written control word exactly, including bits [1:0] of a 1xx code, from the cycle after the write, whether or not `conv_busy` was high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock for the block |
| rst | input | 1 | Synchronous reset, active high |
| bus_ce | input | 1 | Bus-clock tick enable |
| osc_ce | input | 1 | External oscillator tick enable |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 4 | Control word: bit 3 source select, bits [2:0] divide code |
| rd_data | output | 4 | Stored control word |
| conv_busy | input | 1 | Converter busy; freezes the active setting |
| conv_ce | output | 1 | Conversion clock enable pulse |

## Verification
The assertions assume that reset is held for at least two clock edges at start-up, so that every register holds a defined value before any past-value comparison is made. They also assume that `wr_data` is stable and known whenever `wr_en` is high. The stimulus starts with several reset cycles and drives every input to a defined level at each falling edge. It writes control words only through the strobe and moves `conv_busy` independently of the tick pattern, so that writes land before, during and after busy windows.

// File: rtl/adc_pre_pkg.sv
package adc_pre_pkg;
  localparam int DIV_W     = 3;
  localparam int CTRL_W    = DIV_W + 1;
  localparam int MAX_SHIFT = 4;
  localparam int SHIFT_W   = 3;
  localparam int CNT_W     = MAX_SHIFT;

  typedef struct packed {
    logic             use_bus;
    logic [DIV_W-1:0] div_code;
  } pre_ctrl_t;

  // Top bit of the code saturates the ratio; otherwise low bits are a shift.
  function automatic logic [SHIFT_W-1:0] code_to_shift(input logic [DIV_W-1:0] code);
    if (code[DIV_W-1]) return SHIFT_W'(MAX_SHIFT);
    return SHIFT_W'(code[DIV_W-2:0]);
  endfunction
endpackage

// File: rtl/adc_pre_ctrl.sv
module adc_pre_ctrl
  import adc_pre_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  pre_ctrl_t wr_data,
  input  logic      conv_busy,
  output pre_ctrl_t shadow,
  output pre_ctrl_t active,
  output logic      restart
);
  logic pend;

  assign restart = !conv_busy && (wr_en || pend);

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow <= '0;
      active <= '0;
      pend   <= 1'b0;
    end else begin
      if (wr_en) shadow <= wr_data;
      if (restart) active <= wr_en ? wr_data : shadow;
      pend <= conv_busy && (pend || wr_en);
    end
  end

  AST_HOLD_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(conv_busy)) |-> $stable(active)); // R5

  AST_PENDING_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(pend) && !$past(conv_busy)) |-> !pend); // R6

  AST_READBACK_EXACT: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(wr_en)) |-> (shadow == $past(wr_data))); // R8
endmodule

// File: rtl/adc_pre_div.sv
module adc_pre_div
  import adc_pre_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      bus_ce,
  input  logic      osc_ce,
  input  pre_ctrl_t active,
  input  logic      restart,
  output logic      conv_ce
);
  logic [CW-1:0]      cnt;
  logic [CW-1:0]      limit;
  logic [SHIFT_W-1:0] shift;
  logic               src_en;
  logic               terminal;

  assign src_en   = active.use_bus ? bus_ce : osc_ce;
  assign shift    = code_to_shift(active.div_code);
  assign limit    = CW'((32'd1 << shift) - 32'd1);
  assign terminal = (cnt == limit);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt     <= '0;
      conv_ce <= 1'b0;
    end else if (restart) begin
      cnt     <= '0;
      conv_ce <= 1'b0;
    end else if (src_en) begin
      conv_ce <= terminal;
      cnt     <= terminal ? '0 : cnt + CW'(1);
    end else begin
      conv_ce <= 1'b0;
    end
  end

  AST_PULSE_FROM_SOURCE: assert property (@(posedge clk) disable iff (rst)
    conv_ce |-> $past(src_en)); // R1

  AST_QUIET_AFTER_APPLY: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(restart)) |-> !conv_ce); // R7
endmodule

// File: rtl/adc_clk_prescaler.sv
module adc_clk_prescaler
  import adc_pre_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_ce,
  input  logic              osc_ce,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              conv_busy,
  output logic              conv_ce
);
  pre_ctrl_t shadow;
  pre_ctrl_t active;
  logic      restart;

  adc_pre_ctrl u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (pre_ctrl_t'(wr_data)),
    .conv_busy (conv_busy),
    .shadow    (shadow),
    .active    (active),
    .restart   (restart)
  );

  adc_pre_div #(.CW(CNT_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .bus_ce  (bus_ce),
    .osc_ce  (osc_ce),
    .active  (active),
    .restart (restart),
    .conv_ce (conv_ce)
  );

  assign rd_data = shadow;
endmodule

// File: tb/test_adc_clk_prescaler.sv
`timescale 1ns/1ps
module test_adc_clk_prescaler;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_ce = 1'b0;
  logic       osc_ce = 1'b0;
  logic       wr_en = 1'b0;
  logic [3:0] wr_data = 4'd0;
  logic [3:0] rd_data;
  logic       conv_busy = 1'b0;
  logic       conv_ce;

  always #2 clk = ~clk;

  adc_clk_prescaler i_adc_clk_prescaler (
    .clk(clk), .rst(rst), .bus_ce(bus_ce), .osc_ce(osc_ce),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .conv_busy(conv_busy), .conv_ce(conv_ce)
  );

  typedef struct {
    logic       ce;
    logic [3:0] rd;
    string      tag;
  } item_t;

  item_t q[$];
  item_t it;
  int total = 0;
  int bad = 0;

  logic [3:0] m_shadow = 4'd0;
  logic [3:0] m_active = 4'd0;
  logic       m_pend = 1'b0;
  int         m_cnt = 0;
  logic [7:0] lf = 8'hA5;

  function automatic int ratio_of(input logic [2:0] code);
    if (code[2]) return 16;
    return 1 << code[1:0];
  endfunction

  task automatic next_lf();
    lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
  endtask

  task automatic step(input logic r, input logic b, input logic o,
                      input logic w, input logic [3:0] d, input logic bz,
                      input string tag);
    logic e;
    logic src;
    logic apply;
    int   n;
    @(negedge clk);
    rst = r; bus_ce = b; osc_ce = o; wr_en = w; wr_data = d; conv_busy = bz;
    e = 1'b0;
    if (r) begin
      m_shadow = 4'd0; m_active = 4'd0; m_pend = 1'b0; m_cnt = 0;
    end else begin
      apply = !bz && (w || m_pend);
      src   = m_active[3] ? b : o;
      n     = ratio_of(m_active[2:0]);
      if (apply) begin
        m_cnt = 0;
        m_active = w ? d : m_shadow;
      end else if (src) begin
        if (m_cnt == n - 1) begin
          e = 1'b1; m_cnt = 0;
        end else begin
          m_cnt++;
        end
      end
      if (w) m_shadow = d;
      m_pend = bz && (m_pend || w);
    end
    q.push_back('{e, m_shadow, tag});
  endtask

  // Monitor: scoreboard pop and compare, 1 ns after each rising edge.
  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      total += 2;
      if (conv_ce !== it.ce) begin
        bad++;
        $display("FAIL %s conv_ce actual=%b expected=%b", it.tag, conv_ce, it.ce);
      end
      if (rd_data !== it.rd) begin
        bad++;
        $display("FAIL %s rd_data actual=%h expected=%h", it.tag, rd_data, it.rd);
      end
    end
  end

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R4: reset state, then default source and ratio
    for (int i = 0; i < 3; i++) step(1, 1, 1, 0, 4'd0, 0, "R4");
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 4'd0, 0, "R4");
    // R3: bus ticks ignored while oscillator is selected
    for (int i = 0; i < 12; i++) step(0, 1, 0, 0, 4'd0, 0, "R3");
    // R1: ratios 1, 2, 4, 8 on the bus source with irregular ticks
    for (int c = 0; c < 4; c++) begin
      step(0, 0, 0, 1, {1'b1, 3'(c)}, 0, "R1");
      for (int i = 0; i < 40; i++) begin
        next_lf();
        step(0, lf[0], lf[1], 0, 4'd0, 0, "R1");
      end
    end
    // R2: all 1xx codes give divide-by-16 on the oscillator
    for (int c = 4; c < 8; c++) begin
      step(0, 0, 1, 1, {1'b0, 3'(c)}, 0, "R2");
      for (int i = 0; i < 40; i++) begin
        next_lf();
        step(0, lf[2], 1, 0, 4'd0, 0, "R2");
      end
    end
    // R3: bus selected, oscillator ticks ignored, then bus ticks counted
    step(0, 0, 0, 1, 4'b1001, 0, "R3");
    for (int i = 0; i < 10; i++) step(0, 0, 1, 0, 4'd0, 0, "R3");
    for (int i = 0; i < 10; i++) step(0, 1, 0, 0, 4'd0, 0, "R3");
    // R5: write during busy must not disturb the running /8 bus setting
    step(0, 0, 0, 1, 4'b1011, 0, "R5");
    for (int i = 0; i < 5; i++) step(0, 1, 1, 0, 4'd0, 0, "R5");
    step(0, 1, 1, 1, 4'b0000, 1, "R5");
    for (int i = 0; i < 20; i++) step(0, 1, 1, 0, 4'd0, 1, "R5");
    step(0, 1, 1, 1, 4'b0001, 1, "R5");
    for (int i = 0; i < 6; i++) step(0, 1, 1, 0, 4'd0, 1, "R5");
    // R6: pending /2 oscillator setting applied on first busy-low edge
    for (int i = 0; i < 12; i++) step(0, 0, 1, 0, 4'd0, 0, "R6");
    // R6: fresh write at the release edge beats the pending one
    step(0, 1, 1, 1, 4'b1010, 1, "R6");
    step(0, 1, 1, 1, 4'b0000, 0, "R6");
    for (int i = 0; i < 8; i++) step(0, 1, 1, 0, 4'd0, 0, "R6");
    // R7: rewriting the same setting restarts the count mid-period
    step(0, 0, 0, 1, 4'b0010, 0, "R7");
    for (int i = 0; i < 2; i++) step(0, 0, 1, 0, 4'd0, 0, "R7");
    step(0, 0, 1, 1, 4'b0010, 0, "R7");
    for (int i = 0; i < 9; i++) step(0, 0, 1, 0, 4'd0, 0, "R7");
    step(0, 0, 1, 1, 4'b0000, 0, "R7");
    step(0, 0, 1, 0, 4'd0, 0, "R7");
    // R8: exact readback, busy or not
    step(0, 0, 0, 1, 4'b1110, 0, "R8");
    step(0, 0, 0, 1, 4'b0101, 1, "R8");
    step(0, 0, 0, 1, 4'b1111, 1, "R8");
    step(0, 0, 0, 0, 4'd0, 1, "R8");
    for (int i = 0; i < 20; i++) step(0, 0, 1, 0, 4'd0, 0, "R8");
    @(negedge clk);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule